// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a small stored-program processor. It has one accumulator as the implicit operand and one memory that holds both code and data. A hardwired control state machine moves words between a program counter, a memory address register, a memory buffer register, an instruction register and the accumulator. One instruction runs over several clock cycles: fetch, decode, an optional operand access, execute, then the program counter advance. The datapath adder is a chain of identical one-bit slices.

Each instruction word is 16 bits. The top two bits select the operation and the low 14 bits give a memory address. There are four operations: load into the accumulator, store from it, add a memory word to it, and jump when it is negative.

The memory port is a request/ready interface. A read or write strobe is the request. It stays asserted, with its address and write data held steady, until the memory raises `mem_ready`. The transfer completes in the cycle where strobe and ready are both high. Read data is sampled in that same cycle. The memory may hold `mem_ready` low for any number of cycles, and the core stalls in that access until ready goes high.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted both strobes are low. The first request after reset is a read of address 0, visible one clock edge after release.
- R2: The instruction word is decoded as opcode = bits [15:14] (00 load, 01 store, 10 add, 11 branch-if-negative) and operand address = bits [13:0]. Each instruction is fetched by a read at the program counter address.
- R3: Load places the word at the operand address into the accumulator.
- R4: Store writes the accumulator to the operand address with exactly one completed write transfer, and the write data equals the accumulator.
- R5: Add replaces the accumulator with the accumulator plus the word at the operand address, modulo 2^16.
- R6: Branch with accumulator bit 15 set makes the next fetch come from the operand address.
- R7: Branch with accumulator bit 15 clear, and every non-branch instruction, advances the program counter by one.
- R8: While a strobe is high and `mem_ready` is low, the strobe, the address and the write data hold their values. Each access then takes exactly one extra cycle per low-ready cycle.
- R9: With `mem_ready` always high, load and add take 6 cycles, store takes 5, a taken branch takes 4 and an untaken branch takes 5.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 14 | Word address of the current access |
| mem_rd | output | 1 | Read request strobe |
| mem_wr | output | 1 | Write request strobe |
| mem_wdata | output | 16 | Write data, valid with `mem_wr` |
| mem_rdata | input | 16 | Read data, sampled when `mem_rd` and `mem_ready` are high |
| mem_ready | input | 1 | Memory accepts or completes the current access |

## Verification
Assertions check the following on every cycle:
- The two strobes never overlap.
- A stalled request keeps its strobe, address and write data.
- Write data always equals the accumulator.
- The accumulator and program counter take the correct value after each load, add, jump or advance step.

The bench must show what the assertions cannot:
- Whole programs in memory produce the right stored results across sweeps of operand values, including carry wrap and the sign boundary.
- Branches reach the correct next instruction.
- Total cycle counts match the per-instruction cost plus one cycle per stalled memory cycle.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_ADD   = 2'b10,
    OP_BRNEG = 2'b11
  } acc_op_e;

  typedef enum logic [2:0] {
    ST_FETCH_A,
    ST_FETCH_M,
    ST_DECODE,
    ST_OPER_RD,
    ST_OPER_WR,
    ST_EXEC,
    ST_BRANCH,
    ST_ADVANCE
  } acc_state_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic ir_load;
    logic mbr_from_mem;
    logic mbr_from_ac;
    logic ac_from_mbr;
    logic ac_from_sum;
    logic pc_jump;
    logic pc_step;
  } acc_ctl_t;

endpackage

// File: rtl/acc_adder.sv
module acc_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum
);

  logic [WIDTH-1:0] carry;

  assign carry[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_slice
      assign sum[i] = a[i] ^ b[i] ^ carry[i];
      if (i < WIDTH - 1) begin : g_cy
        assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
      end
    end
  endgenerate

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  acc_op_e  opcode,
  input  logic     ac_neg,
  input  logic     mem_ready,
  output acc_ctl_t ctl,
  output logic     mem_rd,
  output logic     mem_wr
);

  acc_state_e state, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FETCH_A;
    else        state <= nxt;
  end

  always_comb begin
    ctl    = '0;
    mem_rd = 1'b0;
    mem_wr = 1'b0;
    nxt    = state;
    case (state)
      ST_FETCH_A: begin
        ctl.mar_from_pc = 1'b1;
        nxt = ST_FETCH_M;
      end
      ST_FETCH_M: begin
        mem_rd = 1'b1;
        if (mem_ready) begin
          ctl.ir_load = 1'b1;
          nxt = ST_DECODE;
        end
      end
      ST_DECODE: begin
        case (opcode)
          OP_BRNEG: nxt = ST_BRANCH;
          OP_STORE: begin
            ctl.mar_from_ir = 1'b1;
            ctl.mbr_from_ac = 1'b1;
            nxt = ST_OPER_WR;
          end
          default: begin
            ctl.mar_from_ir = 1'b1;
            nxt = ST_OPER_RD;
          end
        endcase
      end
      ST_OPER_RD: begin
        mem_rd = 1'b1;
        if (mem_ready) begin
          ctl.mbr_from_mem = 1'b1;
          nxt = ST_EXEC;
        end
      end
      ST_OPER_WR: begin
        mem_wr = 1'b1;
        if (mem_ready) nxt = ST_ADVANCE;
      end
      ST_EXEC: begin
        if (opcode == OP_ADD) ctl.ac_from_sum = 1'b1;
        else                  ctl.ac_from_mbr = 1'b1;
        nxt = ST_ADVANCE;
      end
      ST_BRANCH: begin
        if (ac_neg) begin
          ctl.pc_jump = 1'b1;
          nxt = ST_FETCH_A;
        end else begin
          nxt = ST_ADVANCE;
        end
      end
      ST_ADVANCE: begin
        ctl.pc_step = 1'b1;
        nxt = ST_FETCH_A;
      end
      default: nxt = ST_FETCH_A;
    endcase
  end

  // R10
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> mem_rd);

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready) |=> mem_wr);

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_ctl_t          ctl,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic [DATA_W-1:0] ac,
  output acc_op_e           opcode,
  output logic              ac_neg
);

  localparam int OP_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] sum;
  logic [ADDR_W-1:0] ir_addr;

  assign ir_addr = ir[ADDR_W-1:0];
  assign opcode  = acc_op_e'(ir[DATA_W-1 -: OP_W]);
  assign ac_neg  = ac[DATA_W-1];

  acc_adder #(.WIDTH(DATA_W)) u_adder (
    .a   (ac),
    .b   (mbr),
    .sum (sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      mar <= '0;
      ir  <= '0;
      mbr <= '0;
      ac  <= '0;
    end else begin
      if (ctl.mar_from_pc)       mar <= pc;
      else if (ctl.mar_from_ir)  mar <= ir_addr;
      if (ctl.ir_load)           ir  <= mem_rdata;
      if (ctl.mbr_from_mem)      mbr <= mem_rdata;
      else if (ctl.mbr_from_ac)  mbr <= ac;
      if (ctl.ac_from_sum)       ac  <= sum;
      else if (ctl.ac_from_mbr)  ac  <= mbr;
      if (ctl.pc_jump)           pc  <= ir_addr;
      else if (ctl.pc_step)      pc  <= pc + 1'b1;
    end
  end

  // R5
  ac_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ac_from_sum |=> (ac == DATA_W'($past(ac) + $past(mbr))));

  // R3
  ac_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ac_from_mbr |=> (ac == $past(mbr)));

  // R6
  br_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.pc_jump |=> (pc == $past(ir_addr)));

  // R7
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.pc_step |=> (pc == ADDR_W'($past(pc) + 1'b1)));

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready
);

  acc_ctl_t          ctl;
  acc_op_e           opcode;
  logic              ac_neg;
  logic [DATA_W-1:0] ac;

  acc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .opcode    (opcode),
    .ac_neg    (ac_neg),
    .mem_ready (mem_ready),
    .ctl       (ctl),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
  );

  acc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .mar       (mem_addr),
    .mbr       (mem_wdata),
    .ac        (ac),
    .opcode    (opcode),
    .ac_neg    (ac_neg)
  );

  // R4
  st_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_wdata == ac));

  // R8
  rd_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> $stable(mem_addr));

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_wdata)));

endmodule

// File: tb/tb_acc_core.sv
`timescale 1ns/1ps
module tb_acc_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_ready;

  logic [15:0] mem [0:255];
  logic        pk_en = 1'b0;
  logic [7:0]  pk_a = '0;
  logic [15:0] pk_d = '0;
  int          stall = 0;
  int          wcnt = 0;
  int          wr_done = 0;
  int          checks = 0;
  int          failures = 0;

  always #10 clk = ~clk;

  acc_core dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  assign mem_ready = (mem_rd || mem_wr) && (wcnt == stall);

  always @(posedge clk) begin
    if (pk_en) mem[pk_a] <= pk_d;
    else if (mem_wr && mem_ready) mem[mem_addr[7:0]] <= mem_wdata;
    if (!rst_n) begin
      wcnt <= 0;
      wr_done <= 0;
    end else begin
      if ((mem_rd || mem_wr) && !mem_ready) wcnt <= wcnt + 1;
      else wcnt <= 0;
      if (mem_wr && mem_ready) wr_done <= wr_done + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [15:0] d);
    pk_a = 8'(a);
    pk_d = d;
    pk_en = 1'b1;
    @(posedge clk);
    #1 pk_en = 1'b0;
  endtask

  function automatic logic [15:0] enc(input logic [1:0] op, input int a);
    return {op, 14'(a)};
  endfunction

  function automatic logic [15:0] vgen(input int k);
    case (k)
      0: return 16'hFFFF;
      1: return 16'h8000;
      2: return 16'h7FFF;
      3: return 16'h0001;
      default: return 16'(k * 4919) ^ 16'(k << 11);
    endcase
  endfunction

  task automatic start_reset();
    @(negedge clk);
    rst_n = 1'b0;
  endtask

  // Releases reset and runs until a fetch strobe reaches h1 or h2.
  task automatic run_to(input int h1, input int h2, output int cyc,
                        output int hit, output int first_cyc, output int first_addr);
    chk(!mem_rd && !mem_wr, "R1 strobes low in reset", {mem_rd, mem_wr}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    hit = -1;
    first_cyc = -1;
    first_addr = -1;
    while (cyc < 2000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (first_cyc < 0 && (mem_rd || mem_wr)) begin
        first_cyc = cyc;
        first_addr = int'(mem_addr) + (mem_wr ? 32'h10000 : 0);
      end
      if (mem_rd && (int'(mem_addr) == h1 || int'(mem_addr) == h2)) begin
        hit = int'(mem_addr);
        break;
      end
    end
  endtask

  initial begin
    int cyc, hit, fc, fa;
    // Add sweep: LD 100; ADD 101; ST 102; stop at fetch of 3.
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [15:0] a, b, s;
        a = vgen(i);
        b = vgen(j + 3);
        s = a + b;
        stall = (i + j) % 3;
        start_reset();
        poke(0, enc(2'b00, 100));
        poke(1, enc(2'b10, 101));
        poke(2, enc(2'b01, 102));
        poke(100, a);
        poke(101, b);
        poke(102, 16'hDEAD);
        run_to(3, 3, cyc, hit, fc, fa);
        if (i == 0 && j == 0)
          chk(fc == 1 && fa == 0, "R1 first request is read of 0", fa, 0);
        chk(hit == 3, "R2 fetch reaches address 3", hit, 3);
        chk(mem[102] == s, "R5 add result stored", mem[102], s);
        chk(wr_done == 1, "R4 one write per store", wr_done, 1);
        chk(cyc == 18 + 6 * stall, "R8/R9 add program cycles", cyc, 18 + 6 * stall);
      end
    end
    // Load/store sweep: LD 100; ST 101; stop at fetch of 2.
    for (int k = 0; k < 32; k++) begin
      logic [15:0] v;
      v = vgen(k);
      stall = k % 4;
      start_reset();
      poke(0, enc(2'b00, 100));
      poke(1, enc(2'b01, 101));
      poke(100, v);
      poke(101, ~v);
      run_to(2, 2, cyc, hit, fc, fa);
      chk(mem[101] == v, "R3 loaded value stored back", mem[101], v);
      chk(wr_done == 1, "R4 single write", wr_done, 1);
      chk(cyc == 12 + 4 * stall, "R9 load+store cycles", cyc, 12 + 4 * stall);
    end
    // Branch sweep: LD 100; BRN 5; ST 101; stop at fetch of 3 or 5.
    for (int k = 0; k < 32; k++) begin
      logic [15:0] v;
      bit neg;
      v = vgen(k);
      neg = v[15];
      stall = (k / 2) % 3;
      start_reset();
      poke(0, enc(2'b00, 100));
      poke(1, enc(2'b11, 5));
      poke(2, enc(2'b01, 101));
      poke(100, v);
      poke(101, 16'hBEEF);
      run_to(3, 5, cyc, hit, fc, fa);
      if (neg) begin
        chk(hit == 5, "R6 taken branch target", hit, 5);
        chk(mem[101] == 16'hBEEF && wr_done == 0, "R6 skipped store untouched", mem[101], 16'hBEEF);
        chk(cyc == 11 + 3 * stall, "R9 taken branch cycles", cyc, 11 + 3 * stall);
      end else begin
        chk(hit == 3, "R7 untaken branch falls through", hit, 3);
        chk(mem[101] == v, "R7 fall-through store done", mem[101], v);
        chk(cyc == 17 + 5 * stall, "R9 untaken branch cycles", cyc, 17 + 5 * stall);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // R10 observed at the ports on every cycle
  always @(negedge clk) begin
    if (rst_n && mem_rd && mem_wr) begin
      checks++;
      failures++;
      $display("FAIL R10 both strobes high actual=%0d expected=%0d", 1, 0);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule